// File: doc/BRIEF.md
# Receive Process Control State Machine

This block sequences the receive side of a network interface controller. Software sets and clears a run command bit. The block turns that bit into a sequence of descriptor fetches, waits for frames, makes a decision to keep or discard each frame, and gives the descriptor back. It does not move any data. The bus master, the address filter, the data FIFO and the line interface stay outside the block. The block talks to each of them through single-bit pulses or a request/valid pair.

When the run bit rises from the stopped state, the block requests a descriptor. The returned word says in its top bit who owns the buffer. If the host owns it, the block parks in a suspended state and reports that no receive buffer is available. A poll demand or a new frame wakes it up again. If the controller owns it, the block waits for a frame, follows that frame to its end, and then decides whether to keep it. That decision uses the frame's damage flags, the filter result, the promiscuous setting and the pass-bad-frame policy. If software clears the run bit in the middle of a frame, the block finishes that frame before it stops.

Top module: `rx_proc_ctrl`

## Requirements
- R1: After reset the state code is 0 and every output is low. A 0-to-1 change of `run_cmd` seen in the stopped state moves the block to the fetching state on the next cycle. `desc_req` is high in exactly the cycles spent fetching.
- R2: In the fetching state with `run_cmd` high, a `desc_vld` whose word has bit DESC_W-1 equal to 0 (host owned) moves the block to the suspended state. In that same next cycle `buf_unavail` pulses high for one cycle. `buf_unavail` never rises in any other case.
- R3: In the fetching state with `run_cmd` high, a `desc_vld` whose word has bit DESC_W-1 equal to 1 moves the block to waiting. A `frame_sof` seen while waiting moves it to receiving.
- R4: Clearing `run_cmd` in the fetching, waiting or suspended state gives the stopped state on the next cycle, and a stop in the fetching state takes priority over a `desc_vld` in the same cycle. While receiving, a cleared `run_cmd` is held off until `frame_eof`. The frame is still judged, and then the block stops.
- R5: A frame with neither `frame_runt` nor `frame_trunc` set at `frame_eof` is accepted when `addr_hit` or `promisc` is high, and dropped otherwise.
- R6: A frame with `frame_runt` or `frame_trunc` set is always dropped when `pass_bad` is low. When `pass_bad` is high it is accepted only if `addr_hit` or `promisc` is high.
- R7: One cycle after the end of an accepted frame, `frame_accept`, `rx_done` and `desc_release` pulse together, and the block goes to fetching (or to stopped, per R4). A dropped frame pulses `frame_drop` alone and returns the block to waiting.
- R8: In the suspended state with `run_cmd` high, a `poll_demand` or a `frame_sof` starts a new fetch.
- R9: `frame_sof` has no effect outside the waiting and suspended states. `frame_eof` has no effect outside the receiving state: no verdict pulse appears and the state is unchanged.
- R10: `proc_state` encodes 0 stopped, 1 fetching, 2 waiting, 3 receiving, 4 suspended, and never takes another value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_cmd | input | 1 | Software receive run command (level) |
| pass_bad | input | 1 | Keep runt/truncated frames when high |
| promisc | input | 1 | Promiscuous mode, overrides the filter result |
| poll_demand | input | 1 | Receive poll pulse |
| desc_req | output | 1 | Descriptor fetch request |
| desc_vld | input | 1 | Fetched descriptor word is valid |
| desc_word | input | DESC_W | Fetched descriptor word, ownership in the top bit |
| frame_sof | input | 1 | Start of an incoming frame |
| frame_eof | input | 1 | End of the current frame, qualifies the flags below |
| frame_runt | input | 1 | Frame was too short |
| frame_trunc | input | 1 | Frame was cut by FIFO overflow |
| addr_hit | input | 1 | Address filter passed the frame |
| frame_accept | output | 1 | Frame kept (pulse) |
| frame_drop | output | 1 | Frame discarded (pulse) |
| rx_done | output | 1 | Receive-complete status (pulse) |
| desc_release | output | 1 | Hand descriptor back to host (pulse) |
| buf_unavail | output | 1 | Receive buffer unavailable status (pulse) |
| proc_state | output | 3 | Encoded process state |

## Verification
Two functions can fall in the same cycle. The graceful stop can meet the end of a frame, and the stop command can meet a returning descriptor while fetching. The bench drives `run_cmd` low together with `frame_eof`, and also together with `desc_vld`. It then checks the verdict pulses, the absence of `buf_unavail` and the stopped state code one cycle later. A behavioural model runs alongside on random traffic that crowds these inputs together, and the bench compares every output with the model on every cycle.

// File: rtl/rx_ctrl_pkg.sv
package rx_ctrl_pkg;

  typedef enum logic [2:0] {
    RX_STOP  = 3'd0,
    RX_FETCH = 3'd1,
    RX_WAIT  = 3'd2,
    RX_RECV  = 3'd3,
    RX_SUSP  = 3'd4
  } rx_state_e;

  typedef struct packed {
    logic accept;
    logic drop;
    logic done;
    logic release_d;
    logic unavail;
  } rx_pulse_t;

  localparam int unsigned PULSE_W = 5;

  // keep decision: filter must pass, damage only tolerated with pass_bad
  function automatic logic keep_frame(input logic runt, input logic trunc,
                                      input logic pass_bad, input logic addr_ok,
                                      input logic promisc);
    logic damaged;
    logic filt_ok;
    damaged = runt | trunc;
    filt_ok = addr_ok | promisc;
    return filt_ok & (~damaged | pass_bad);
  endfunction

  function automatic logic ctrl_owns(input logic own_bit);
    return own_bit;
  endfunction

endpackage

// File: rtl/rx_start_edge.sv
module rx_start_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_in,
  output logic rise_o
);
  logic cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_q <= 1'b0;
    else        cmd_q <= cmd_in;
  end

  assign rise_o = cmd_in & ~cmd_q;
endmodule

// File: rtl/rx_desc_check.sv
module rx_desc_check #(
  parameter int unsigned DESC_W = 32
) (
  input  logic              vld_i,
  input  logic [DESC_W-1:0] word_i,
  output logic              ctrl_o,
  output logic              host_o
);
  import rx_ctrl_pkg::*;
  localparam int unsigned OWN_POS = DESC_W - 1;

  logic own;
  assign own    = ctrl_owns(word_i[OWN_POS]);
  assign ctrl_o = vld_i & own;
  assign host_o = vld_i & ~own;
endmodule

// File: rtl/rx_frame_judge.sv
module rx_frame_judge (
  input  logic eof_i,
  input  logic runt_i,
  input  logic trunc_i,
  input  logic pass_bad_i,
  input  logic addr_i,
  input  logic promisc_i,
  output logic keep_o,
  output logic toss_o
);
  import rx_ctrl_pkg::*;
  logic verdict;
  assign verdict = keep_frame(runt_i, trunc_i, pass_bad_i, addr_i, promisc_i);
  assign keep_o  = eof_i & verdict;
  assign toss_o  = eof_i & ~verdict;
endmodule

// File: rtl/rx_proc_ctrl.sv
module rx_proc_ctrl #(
  parameter int unsigned DESC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_cmd,
  input  logic              pass_bad,
  input  logic              promisc,
  input  logic              poll_demand,
  output logic              desc_req,
  input  logic              desc_vld,
  input  logic [DESC_W-1:0] desc_word,
  input  logic              frame_sof,
  input  logic              frame_eof,
  input  logic              frame_runt,
  input  logic              frame_trunc,
  input  logic              addr_hit,
  output logic              frame_accept,
  output logic              frame_drop,
  output logic              rx_done,
  output logic              desc_release,
  output logic              buf_unavail,
  output logic [2:0]        proc_state
);
  import rx_ctrl_pkg::*;

  rx_state_e state_q, state_d;
  rx_pulse_t pulse_q, pulse_d;

  // named internal events
  logic start_rise_w;
  logic ctrl_owned_w;
  logic host_owned_w;
  logic eof_in_recv_w;
  logic keep_w;
  logic toss_w;

  rx_start_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_in (run_cmd),
    .rise_o (start_rise_w)
  );

  rx_desc_check #(.DESC_W(DESC_W)) u_desc (
    .vld_i  (desc_vld),
    .word_i (desc_word),
    .ctrl_o (ctrl_owned_w),
    .host_o (host_owned_w)
  );

  assign eof_in_recv_w = frame_eof & (state_q == RX_RECV);

  rx_frame_judge u_judge (
    .eof_i      (eof_in_recv_w),
    .runt_i     (frame_runt),
    .trunc_i    (frame_trunc),
    .pass_bad_i (pass_bad),
    .addr_i     (addr_hit),
    .promisc_i  (promisc),
    .keep_o     (keep_w),
    .toss_o     (toss_w)
  );

  always_comb begin
    state_d = state_q;
    pulse_d = '0;
    unique case (state_q)
      RX_STOP: begin
        if (start_rise_w) state_d = RX_FETCH;
      end
      RX_FETCH: begin
        if (!run_cmd) begin
          state_d = RX_STOP;
        end else if (ctrl_owned_w) begin
          state_d = RX_WAIT;
        end else if (host_owned_w) begin
          state_d         = RX_SUSP;
          pulse_d.unavail = 1'b1;
        end
      end
      RX_WAIT: begin
        if (!run_cmd)       state_d = RX_STOP;
        else if (frame_sof) state_d = RX_RECV;
      end
      RX_RECV: begin
        if (keep_w) begin
          pulse_d.accept    = 1'b1;
          pulse_d.done      = 1'b1;
          pulse_d.release_d = 1'b1;
          state_d           = run_cmd ? RX_FETCH : RX_STOP;
        end else if (toss_w) begin
          pulse_d.drop = 1'b1;
          state_d      = run_cmd ? RX_WAIT : RX_STOP;
        end
      end
      RX_SUSP: begin
        if (!run_cmd)                       state_d = RX_STOP;
        else if (poll_demand || frame_sof)  state_d = RX_FETCH;
      end
      default: state_d = RX_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RX_STOP;
      pulse_q <= '0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
    end
  end

  assign desc_req     = (state_q == RX_FETCH);
  assign frame_accept = pulse_q.accept;
  assign frame_drop   = pulse_q.drop;
  assign rx_done      = pulse_q.done;
  assign desc_release = pulse_q.release_d;
  assign buf_unavail  = pulse_q.unavail;
  assign proc_state   = state_q;
endmodule

// File: rtl/rx_proc_ctrl_chk.sv
module rx_proc_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run_cmd,
  input logic       pass_bad,
  input logic       promisc,
  input logic       poll_demand,
  input logic       desc_req,
  input logic       frame_sof,
  input logic       frame_eof,
  input logic       frame_runt,
  input logic       frame_trunc,
  input logic       addr_hit,
  input logic       frame_accept,
  input logic       frame_drop,
  input logic       rx_done,
  input logic       desc_release,
  input logic       buf_unavail,
  input logic [2:0] proc_state,
  input logic       start_rise_w,
  input logic       ctrl_owned_w,
  input logic       host_owned_w
);
  p_start_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_state == 3'd0 && start_rise_w) |=> (proc_state == 3'd1 && desc_req));

  p_host_susp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_state == 3'd1 && run_cmd && host_owned_w) |=> (proc_state == 3'd4 && buf_unavail));

  p_unavail_in_susp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    buf_unavail |-> proc_state == 3'd4);

  p_ctrl_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_state == 3'd1 && run_cmd && ctrl_owned_w) |=> proc_state == 3'd2);

  p_recv_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_state == 3'd3 && !frame_eof) |=> proc_state == 3'd3);

  p_stop_after_eof_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_state == 3'd3 && frame_eof && !run_cmd) |=> proc_state == 3'd0);

  p_idle_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((proc_state == 3'd1 || proc_state == 3'd2 || proc_state == 3'd4) && !run_cmd)
      |=> proc_state == 3'd0);

  p_verdict_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_accept && frame_drop));

  p_accept_filter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_accept |-> $past(addr_hit || promisc));

  p_bad_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_state == 3'd3 && frame_eof && !pass_bad && (frame_runt || frame_trunc))
      |=> frame_drop);

  p_release_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    desc_release |-> (rx_done && frame_accept));

  p_drop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_drop |-> (!rx_done && !desc_release));

  p_susp_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_state == 3'd4 && run_cmd && (poll_demand || frame_sof)) |=> proc_state == 3'd1);

  p_stray_eof_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_state != 3'd3) |=> !(frame_accept || frame_drop));

  p_legal_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    proc_state <= 3'd4);
endmodule

bind rx_proc_ctrl rx_proc_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run_cmd      (run_cmd),
  .pass_bad     (pass_bad),
  .promisc      (promisc),
  .poll_demand  (poll_demand),
  .desc_req     (desc_req),
  .frame_sof    (frame_sof),
  .frame_eof    (frame_eof),
  .frame_runt   (frame_runt),
  .frame_trunc  (frame_trunc),
  .addr_hit     (addr_hit),
  .frame_accept (frame_accept),
  .frame_drop   (frame_drop),
  .rx_done      (rx_done),
  .desc_release (desc_release),
  .buf_unavail  (buf_unavail),
  .proc_state   (proc_state),
  .start_rise_w (start_rise_w),
  .ctrl_owned_w (ctrl_owned_w),
  .host_owned_w (host_owned_w)
);

// File: tb/tb_rx_proc_ctrl.sv
module tb_rx_proc_ctrl;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_cmd = 0, pass_bad = 0, promisc = 0, poll_demand = 0;
  logic desc_vld = 0;
  logic [DW-1:0] desc_word = '0;
  logic frame_sof = 0, frame_eof = 0, frame_runt = 0, frame_trunc = 0, addr_hit = 0;
  logic desc_req, frame_accept, frame_drop, rx_done, desc_release, buf_unavail;
  logic [2:0] proc_state;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rx_proc_ctrl #(.DESC_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .run_cmd(run_cmd), .pass_bad(pass_bad),
    .promisc(promisc), .poll_demand(poll_demand), .desc_req(desc_req),
    .desc_vld(desc_vld), .desc_word(desc_word), .frame_sof(frame_sof),
    .frame_eof(frame_eof), .frame_runt(frame_runt), .frame_trunc(frame_trunc),
    .addr_hit(addr_hit), .frame_accept(frame_accept), .frame_drop(frame_drop),
    .rx_done(rx_done), .desc_release(desc_release), .buf_unavail(buf_unavail),
    .proc_state(proc_state)
  );

  // behavioural reference model
  int m_st = 0;
  bit m_prev = 0;
  bit m_acc = 0, m_drop = 0, m_done = 0, m_rel = 0, m_bu = 0;

  always @(posedge clk) begin
    bit ok;
    if (!rst_n) begin
      m_st <= 0; m_prev <= 0;
      {m_acc, m_drop, m_done, m_rel, m_bu} <= '0;
    end else begin
      m_prev <= run_cmd;
      {m_acc, m_drop, m_done, m_rel, m_bu} <= '0;
      if (m_st == 0) begin
        if (run_cmd && !m_prev) m_st <= 1;
      end else if (m_st == 3) begin
        if (frame_eof) begin
          ok = (addr_hit || promisc);
          if (frame_runt || frame_trunc) ok = ok && pass_bad;
          if (ok) begin
            m_acc <= 1; m_done <= 1; m_rel <= 1;
            m_st <= run_cmd ? 1 : 0;
          end else begin
            m_drop <= 1;
            m_st <= run_cmd ? 2 : 0;
          end
        end
      end else if (!run_cmd) begin
        m_st <= 0;
      end else if (m_st == 1) begin
        if (desc_vld) begin
          if (desc_word[DW-1]) m_st <= 2;
          else begin m_st <= 4; m_bu <= 1; end
        end
      end else if (m_st == 2) begin
        if (frame_sof) m_st <= 3;
      end else if (m_st == 4) begin
        if (poll_demand || frame_sof) m_st <= 1;
      end
    end
  end

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  bit cmp_en = 0;
  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      chk(int'(proc_state) == m_st, "R10 state vs model", proc_state, m_st);
      chk(desc_req == (m_st == 1), "R1 desc_req vs model", desc_req, (m_st == 1));
      chk(buf_unavail == m_bu, "R2 buf_unavail vs model", buf_unavail, m_bu);
      chk(frame_accept == m_acc && frame_drop == m_drop, "R5 verdict vs model",
          {frame_accept, frame_drop}, {m_acc, m_drop});
      chk(rx_done == m_done && desc_release == m_rel, "R7 done/release vs model",
          {rx_done, desc_release}, {m_done, m_rel});
    end
  end

  task automatic cyc();
    @(negedge clk);
    poll_demand = 0; desc_vld = 0; frame_sof = 0; frame_eof = 0;
    frame_runt = 0; frame_trunc = 0; addr_hit = 0;
  endtask

  task automatic give_desc(input bit ctrl);
    desc_vld = 1; desc_word = {ctrl, 31'h1234};
    cyc();
  endtask

  task automatic end_frame(input bit runt, input bit trunc, input bit addr);
    frame_eof = 1; frame_runt = runt; frame_trunc = trunc; addr_hit = addr;
    cyc();
  endtask

  task automatic expect_out(input string tag, input int st, input bit acc,
                            input bit drp, input bit dn, input bit bu);
    chk(int'(proc_state) == st, tag, proc_state, st);
    chk(frame_accept == acc && frame_drop == drp && rx_done == dn && desc_release == dn,
        tag, {frame_accept, frame_drop, rx_done, desc_release}, {acc, drp, dn, dn});
    chk(buf_unavail == bu, tag, buf_unavail, bu);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_en = 1;
    expect_out("R1 reset state", 0, 0, 0, 0, 0);
    chk(desc_req == 0, "R1 reset req", desc_req, 0);

    run_cmd = 1; cyc();
    expect_out("R1 start fetch", 1, 0, 0, 0, 0);
    chk(desc_req == 1, "R1 req while fetching", desc_req, 1);

    give_desc(0);
    expect_out("R2 host owned suspends", 4, 0, 0, 0, 1);
    cyc();
    expect_out("R2 unavail single pulse", 4, 0, 0, 0, 0);

    end_frame(0, 0, 1);
    expect_out("R9 eof in suspended ignored", 4, 0, 0, 0, 0);
    poll_demand = 1; cyc();
    expect_out("R8 poll wakes fetch", 1, 0, 0, 0, 0);

    give_desc(1);
    expect_out("R3 ctrl owned waits", 2, 0, 0, 0, 0);
    end_frame(0, 0, 1);
    expect_out("R9 eof in waiting ignored", 2, 0, 0, 0, 0);
    frame_sof = 1; cyc();
    expect_out("R3 sof starts receive", 3, 0, 0, 0, 0);
    frame_sof = 1; cyc();
    expect_out("R9 sof in receiving ignored", 3, 0, 0, 0, 0);

    end_frame(0, 0, 1);
    expect_out("R7 good frame accepted", 1, 1, 0, 1, 0);

    give_desc(1); frame_sof = 1; cyc();
    end_frame(0, 0, 0);
    expect_out("R5 filter miss dropped", 2, 0, 1, 0, 0);

    frame_sof = 1; cyc();
    end_frame(1, 0, 1);
    expect_out("R6 runt dropped without pass_bad", 2, 0, 1, 0, 0);

    pass_bad = 1;
    frame_sof = 1; cyc();
    end_frame(0, 1, 0);
    expect_out("R6 truncated, filter miss, dropped", 2, 0, 1, 0, 0);
    promisc = 1;
    frame_sof = 1; cyc();
    end_frame(1, 0, 0);
    expect_out("R6 runt kept via promisc", 1, 1, 0, 1, 0);
    promisc = 0; pass_bad = 0;

    give_desc(1); frame_sof = 1; cyc();
    run_cmd = 0; cyc(); cyc();
    expect_out("R4 stop deferred while receiving", 3, 0, 0, 0, 0);
    end_frame(0, 0, 1);
    expect_out("R4 stop after eof", 0, 1, 0, 1, 0);

    run_cmd = 1; cyc();
    expect_out("R1 restart", 1, 0, 0, 0, 0);
    run_cmd = 0; desc_vld = 1; desc_word = '0; cyc();
    expect_out("R4 stop beats descriptor", 0, 0, 0, 0, 0);

    run_cmd = 1; cyc();
    give_desc(0);
    frame_sof = 1; cyc();
    expect_out("R8 frame wakes suspended", 1, 0, 0, 0, 0);
    give_desc(1);
    run_cmd = 0; cyc();
    expect_out("R4 idle stop", 0, 0, 0, 0, 0);

    // random traffic, model compared every cycle
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) run_cmd = ~run_cmd;
      pass_bad    = $urandom_range(0, 1);
      promisc     = ($urandom_range(0, 3) == 0);
      poll_demand = ($urandom_range(0, 7) == 0);
      desc_vld    = $urandom_range(0, 1);
      desc_word   = $urandom;
      frame_sof   = ($urandom_range(0, 3) == 0);
      frame_eof   = ($urandom_range(0, 3) == 0);
      frame_runt  = ($urandom_range(0, 3) == 0);
      frame_trunc = ($urandom_range(0, 3) == 0);
      addr_hit    = $urandom_range(0, 1);
      @(negedge clk);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule